// File: doc/BRIEF.md
# External Interrupt Wake Controller

This block watches a single external interrupt pin on behalf of a small processor core that runs in one of three power states: normal, idle and powerdown. While the core is running, the pin is resynchronised into the clock domain and looked at only during clock phase 2 (the half of each state time in which the output clock is high). A rising edge seen there sets an interrupt pending flag, which stays set until the core acknowledges entry to the service routine with a clear strobe.

When the core asks to sleep, the block takes over the power state. In idle the clock keeps running, so the same edge path is used, and an edge wakes the core only if the interrupt is enabled. In powerdown the clocks are assumed stopped, so a high level on the pin is caught by an asynchronously set latch, and the wake then waits for the oscillator-ready input. Once awake the core is told, by a one-cycle pulse, either to enter the service routine or to continue at the instruction after the one that put it to sleep.

The controller has five states. ST_RUN is normal operation. ST_IDLE and ST_PD are the two sleep states. ST_PD_OSC holds powerdown after a wake while the oscillator settles. ST_RESUME is a single normal-mode cycle that carries the service or continue pulse. The transitions are: ST_RUN to ST_IDLE on an idle request; ST_RUN to ST_PD on a powerdown request; ST_IDLE to ST_RESUME on a phase-2 rising edge with the interrupt enabled; ST_PD to ST_PD_OSC when the synchronised wake latch is set; ST_PD_OSC to ST_RESUME when the oscillator is ready; ST_RESUME to ST_RUN unconditionally.

Top module: `extint_wake_ctrl`

## Requirements
- R1: After reset the mode output is 3'b001 (bit 0 normal, bit 1 idle, bit 2 powerdown), pending is 0 and both wake pulses are 0.
- R2: In normal mode, a rising edge of the pin sets pending at the third clock edge after the pin rises, provided phase2 is high in the cycle ending at that edge. A pin that stays high sets pending only once.
- R3: Pending stays set until a cycle with pend_clr high. If a set and a clear fall in the same cycle, pending ends up set.
- R4: The pin is only sampled when phase2 is high. A high pulse that has fully passed through the two-flop synchroniser while phase2 was low never sets pending.
- R5: The mode output is always one-hot. In ST_RUN, mode_req 2'b01 moves to idle and 2'b10 to powerdown at the next clock edge. Codes 2'b00 and 2'b11 have no effect, and mode_req is ignored in every other state.
- R6: In idle, a phase-2 rising edge with irq_en high sets pending and gives one cycle of normal mode with svc_req high, then ST_RUN. With irq_en low, the edge sets pending and the mode stays idle.
- R7: In powerdown, a high pin level wakes the core whatever the state of irq_en and without needing phase2. The mode stays powerdown until osc_ready is high.
- R8: A powerdown wake with irq_en high in the osc_ready cycle gives svc_req and sets pending. With irq_en low it gives resume_req and leaves pending unchanged.
- R9: svc_req and resume_req are never high together. Each lasts one cycle and appears only in the first normal-mode cycle after a sleep state.
- R10: A rising edge in normal mode never changes the mode output; only pending is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | External interrupt pin, asynchronous |
| phase2 | input | 1 | High during clock phase 2 of each state time |
| irq_en | input | 1 | Interrupt enable bit |
| mode_req | input | 2 | Sleep request from the core: 01 idle, 10 powerdown |
| pend_clr | input | 1 | Pending clear strobe (service entry acknowledge) |
| osc_ready | input | 1 | Oscillator stable after powerdown |
| mode | output | 3 | One-hot power state: bit 0 normal, bit 1 idle, bit 2 powerdown |
| pending | output | 1 | Interrupt pending flag |
| svc_req | output | 1 | One-cycle pulse: enter the service routine |
| resume_req | output | 1 | One-cycle pulse: continue at the next instruction |

## Verification
The bench aims at the cases where the mode and the enable bit interact. An idle edge with the interrupt disabled must leave the core asleep: a design that woke anyway would show mode 001 there. A disabled powerdown wake must give resume_req and not svc_req, so a design that gated powerdown wake on the enable would stay in powerdown forever. It also holds phase2 low across a short pulse, where a design that ignored the phase would set pending, and it holds the pin high and overlaps the clear with a set, where a level detector would set pending over and over and a clear-wins register would drop it.

// File: rtl/extw_pkg.sv
package extw_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_PD     = 3'd2,
        ST_PD_OSC = 3'd3,
        ST_RESUME = 3'd4
    } wake_state_e;

    localparam logic [1:0] MREQ_IDLE = 2'b01;
    localparam logic [1:0] MREQ_PD   = 2'b10;

    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_RUN  = 3'b001;
    localparam logic [MODE_W-1:0] MODE_IDLE = 3'b010;
    localparam logic [MODE_W-1:0] MODE_PD   = 3'b100;

endpackage

// File: rtl/extw_sync.sv
module extw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else begin
                    if (g == 0) begin
                        chain[g] <= d_async;
                    end else begin
                        chain[g] <= chain[(g == 0) ? 0 : g-1];
                    end
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/extw_edge_det.sv
module extw_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic phase2,
    output logic rise
);
    logic pin_s;
    logic last_smp;

    extw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pin_in),
        .q_sync (pin_s)
    );

    // previous phase-2 sample; a held-high pin yields a single rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_smp <= 1'b0;
        end else if (phase2) begin
            last_smp <= pin_s;
        end
    end

    assign rise = phase2 & pin_s & ~last_smp;
endmodule

// File: rtl/extw_pd_latch.sv
module extw_pd_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic in_pd,
    output logic wake_sync
);
    logic set_a;
    logic wake_lat;

    assign set_a = pin_in & in_pd;

    // level capture that needs no running clock; cleared once out of powerdown
    always_ff @(posedge clk or negedge rst_n or posedge set_a) begin
        if (!rst_n) begin
            wake_lat <= 1'b0;
        end else if (set_a) begin
            wake_lat <= 1'b1;
        end else if (!in_pd) begin
            wake_lat <= 1'b0;
        end
    end

    extw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(wake_lat),
        .q_sync (wake_sync)
    );
endmodule

// File: rtl/extw_fsm.sv
module extw_fsm
    import extw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              pd_wake,
    input  logic              irq_en,
    input  logic [1:0]        mode_req,
    input  logic              osc_ready,
    output logic [MODE_W-1:0] mode,
    output logic              in_pd,
    output logic              edge_live,
    output logic              wake_set,
    output logic              svc_req,
    output logic              resume_req
);
    wake_state_e state, state_nx;
    logic        wake_svc, wake_svc_nx;

    always_comb begin
        state_nx    = state;
        wake_svc_nx = wake_svc;
        wake_set    = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (mode_req == MREQ_IDLE) begin
                    state_nx = ST_IDLE;
                end else if (mode_req == MREQ_PD) begin
                    state_nx = ST_PD;
                end
            end
            ST_IDLE: begin
                if (rise && irq_en) begin
                    state_nx    = ST_RESUME;
                    wake_svc_nx = 1'b1;
                end
            end
            ST_PD: begin
                if (pd_wake) begin
                    state_nx = ST_PD_OSC;
                end
            end
            ST_PD_OSC: begin
                if (osc_ready) begin
                    state_nx    = ST_RESUME;
                    wake_svc_nx = irq_en;
                    wake_set    = irq_en;
                end
            end
            ST_RESUME: begin
                state_nx = ST_RUN;
            end
            default: begin
                state_nx = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            wake_svc <= 1'b0;
        end else begin
            state    <= state_nx;
            wake_svc <= wake_svc_nx;
        end
    end

    always_comb begin
        mode       = MODE_RUN;
        in_pd      = 1'b0;
        edge_live  = 1'b0;
        svc_req    = 1'b0;
        resume_req = 1'b0;
        unique case (state)
            ST_RUN: begin
                edge_live = 1'b1;
            end
            ST_IDLE: begin
                mode      = MODE_IDLE;
                edge_live = 1'b1;
            end
            ST_PD, ST_PD_OSC: begin
                mode  = MODE_PD;
                in_pd = 1'b1;
            end
            ST_RESUME: begin
                edge_live  = 1'b1;
                svc_req    = wake_svc;
                resume_req = ~wake_svc;
            end
            default: begin
                mode = MODE_RUN;
            end
        endcase
    end
endmodule

// File: rtl/extint_wake_ctrl.sv
module extint_wake_ctrl
    import extw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_in,
    input  logic        phase2,
    input  logic        irq_en,
    input  logic [1:0]  mode_req,
    input  logic        pend_clr,
    input  logic        osc_ready,
    output logic [2:0]  mode,
    output logic        pending,
    output logic        svc_req,
    output logic        resume_req
);
    logic rise;
    logic pd_wake;
    logic in_pd;
    logic edge_live;
    logic wake_set;
    logic pend_set;

    extw_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(pin_in),
        .phase2(phase2),
        .rise  (rise)
    );

    extw_pd_latch #(.SYNC_STAGES(SYNC_STAGES)) u_pdl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .in_pd    (in_pd),
        .wake_sync(pd_wake)
    );

    extw_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .pd_wake   (pd_wake),
        .irq_en    (irq_en),
        .mode_req  (mode_req),
        .osc_ready (osc_ready),
        .mode      (mode),
        .in_pd     (in_pd),
        .edge_live (edge_live),
        .wake_set  (wake_set),
        .svc_req   (svc_req),
        .resume_req(resume_req)
    );

    assign pend_set = (rise & edge_live) | wake_set;

    // set has priority over the clear strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (pend_set) begin
            pending <= 1'b1;
        end else if (pend_clr) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/extw_checker.sv
module extw_checker
    import extw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       phase2,
    input logic       irq_en,
    input logic       pend_clr,
    input logic       osc_ready,
    input logic [2:0] mode,
    input logic       pending,
    input logic       svc_req,
    input logic       resume_req
);
    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode) == 1);  // R5

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(svc_req && resume_req));  // R9

    AST_SVC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |=> !svc_req);  // R6

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !pend_clr) |=> pending);  // R3

    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(phase2 || (osc_ready && irq_en)));  // R4

    AST_IDLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE && !irq_en) |=> (mode == MODE_IDLE));  // R6

    AST_PD_WAITS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PD && !osc_ready) |=> (mode == MODE_PD));  // R7

    AST_WAKE_PULSE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req || resume_req) |-> (mode == MODE_RUN && $past(mode) != MODE_RUN));  // R9
endmodule

bind extint_wake_ctrl extw_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase2    (phase2),
    .irq_en    (irq_en),
    .pend_clr  (pend_clr),
    .osc_ready (osc_ready),
    .mode      (mode),
    .pending   (pending),
    .svc_req   (svc_req),
    .resume_req(resume_req)
);

// File: tb/sim_extint_wake_ctrl.sv
`timescale 1ns/1ps
module sim_extint_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic       phase2 = 1'b0;
    logic       irq_en = 1'b0;
    logic [1:0] mode_req = 2'b00;
    logic       pend_clr = 1'b0;
    logic       osc_ready = 1'b0;
    logic [2:0] mode;
    logic       pending;
    logic       svc_req;
    logic       resume_req;

    always #5 clk = ~clk;

    extint_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .phase2(phase2),
        .irq_en(irq_en), .mode_req(mode_req), .pend_clr(pend_clr),
        .osc_ready(osc_ready), .mode(mode), .pending(pending),
        .svc_req(svc_req), .resume_req(resume_req)
    );

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit auto_phase = 1'b1;
    int svc_seen = 0;
    int res_seen = 0;
    int pend_high = 0;

    // behavioural reference: 0 run, 1 idle, 2 powerdown, 3 wait osc, 4 resume
    int m_st = 0;
    bit m_s1, m_s2, m_last, m_pend, m_lat, m_ls1, m_ls2, m_kind;

    function automatic logic [2:0] m_mode();
        if (m_st == 1) return 3'b010;
        if (m_st == 2 || m_st == 3) return 3'b100;
        return 3'b001;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_step();
        bit rise, inpd, lat_eff, pset;
        int nst;
        rise    = phase2 && m_s2 && !m_last;
        inpd    = (m_st == 2 || m_st == 3);
        lat_eff = m_lat | (pin_in && inpd);
        nst = m_st;
        pset = rise && (m_st == 0 || m_st == 1 || m_st == 4);
        case (m_st)
            0: if (mode_req == 2'b01) nst = 1; else if (mode_req == 2'b10) nst = 2;
            1: if (rise && irq_en) begin nst = 4; m_kind = 1'b1; end
            2: if (m_ls2) nst = 3;
            3: if (osc_ready) begin nst = 4; m_kind = irq_en; pset = pset | irq_en; end
            default: nst = 0;
        endcase
        if (pset) m_pend = 1'b1; else if (pend_clr) m_pend = 1'b0;
        if (phase2) m_last = m_s2;
        m_s2  = m_s1;
        m_s1  = pin_in;
        m_ls2 = m_ls1;
        m_ls1 = lat_eff;
        m_lat = inpd ? lat_eff : 1'b0;
        m_st  = nst;
    endtask

    // one clock: model follows the posedge, outputs compared at the negedge
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        check("R5 mode", {5'b0, mode}, {5'b0, m_mode()});
        check("R2 pending", {7'b0, pending}, {7'b0, m_pend});
        check("R6 svc_req", {7'b0, svc_req}, {7'b0, (m_st == 4) && m_kind});
        check("R8 resume_req", {7'b0, resume_req}, {7'b0, (m_st == 4) && !m_kind});
        if (svc_req) svc_seen++;
        if (resume_req) res_seen++;
        if (pending) pend_high++;
        if (auto_phase) phase2 = ~phase2;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset mode", {5'b0, mode}, 8'h01);
        check("R1 reset pending", {7'b0, pending}, 8'h00);
        check("R1 reset pulses", {6'b0, svc_req, resume_req}, 8'h00);
        rst_n = 1'b1;
        run(4);

        // R2 / R10: edge in normal mode, pin held high
        pin_in = 1'b1;
        run(8);
        check("R2 pending set", {7'b0, pending}, 8'h01);
        check("R10 mode unchanged", {5'b0, mode}, 8'h01);
        pend_clr = 1'b1; tick(); pend_clr = 1'b0;
        run(6);
        check("R2 held pin sets once", {7'b0, pending}, 8'h00);
        pin_in = 1'b0; run(6);

        // R3: clear held across a set -> set wins for one cycle
        pend_clr = 1'b1; pend_high = 0;
        pin_in = 1'b1; run(10);
        check("R3 set beats clear", pend_high[7:0], 8'h01);
        pend_clr = 1'b0; pin_in = 1'b0; run(6);

        // R4: pulse entirely during phase2 low
        auto_phase = 1'b0; phase2 = 1'b0;
        pin_in = 1'b1; tick(); pin_in = 1'b0; run(6);
        auto_phase = 1'b1; run(6);
        check("R4 unsampled pulse ignored", {7'b0, pending}, 8'h00);

        // R5: reserved code ignored, then idle
        mode_req = 2'b11; run(2);
        check("R5 code 11 ignored", {5'b0, mode}, 8'h01);
        mode_req = 2'b01; tick(); mode_req = 2'b00;
        check("R5 idle entered", {5'b0, mode}, 8'h02);
        mode_req = 2'b10; run(2); mode_req = 2'b00;
        check("R5 request ignored in idle", {5'b0, mode}, 8'h02);

        // R6: idle edge with enable low -> pending, no wake
        irq_en = 1'b0; pin_in = 1'b1; run(8);
        check("R6 idle disabled stays idle", {5'b0, mode}, 8'h02);
        check("R6 idle edge sets pending", {7'b0, pending}, 8'h01);
        pin_in = 1'b0; pend_clr = 1'b1; tick(); pend_clr = 1'b0; run(5);
        irq_en = 1'b1; svc_seen = 0; res_seen = 0;
        pin_in = 1'b1; run(8); pin_in = 1'b0;
        check("R6 idle wake service pulse", svc_seen[7:0], 8'h01);
        check("R9 no resume on idle wake", res_seen[7:0], 8'h00);
        check("R6 back to normal", {5'b0, mode}, 8'h01);
        pend_clr = 1'b1; tick(); pend_clr = 1'b0; run(5);

        // R7 / R8: powerdown wake with enable low
        irq_en = 1'b0; mode_req = 2'b10; tick(); mode_req = 2'b00;
        check("R7 powerdown entered", {5'b0, mode}, 8'h04);
        auto_phase = 1'b0; phase2 = 1'b0;
        pin_in = 1'b1; tick(); pin_in = 1'b0; run(10);
        check("R7 waits for oscillator", {5'b0, mode}, 8'h04);
        svc_seen = 0; res_seen = 0;
        osc_ready = 1'b1; tick(); osc_ready = 1'b0; run(3);
        auto_phase = 1'b1;
        check("R8 disabled wake resumes", res_seen[7:0], 8'h01);
        check("R8 disabled wake no service", svc_seen[7:0], 8'h00);
        check("R8 pending untouched", {7'b0, pending}, 8'h00);
        run(4);

        // R8: powerdown wake with enable high
        irq_en = 1'b1; mode_req = 2'b10; tick(); mode_req = 2'b00;
        pin_in = 1'b1; run(6);
        osc_ready = 1'b1; svc_seen = 0; res_seen = 0;
        run(3); osc_ready = 1'b0; pin_in = 1'b0; run(4);
        check("R8 enabled wake service", svc_seen[7:0], 8'h01);
        check("R9 enabled wake no resume", res_seen[7:0], 8'h00);
        check("R8 enabled wake pending", {7'b0, pending}, 8'h01);
        run(4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule